// File: doc/BRIEF.md
# Load Data Alignment Unit

This block sits between a memory read decoder and a register file. It takes the naturally aligned word (or the aligned halfword in the low 16 bits) that the decoder fetched, the low address bits of the original request and a load-kind code. From these it forms the value to be written back for word, unsigned halfword, signed halfword, unsigned byte and signed byte loads.

A misaligned access never traps. A word load at a non-multiple-of-four address returns the fetched word rotated by whole bytes. An unsigned halfword load at an odd address returns the halfword rotated right by one byte within a 32-bit container. A signed halfword load at an odd address falls back to a sign-extended byte.

The datapath is combinational, with a single output register. A result is valid one clock after its request was presented. When no request is presented, the output register keeps its last value.

Top module: `ld_align_unit`

## Requirements
- R1: While `rst_n` is low, and on the first cycle after it is released, `out_valid` is 0 and `out_data` is 0.
- R2: `out_valid` equals the value `in_valid` had on the previous rising clock edge. The result for a request sampled at edge N is on `out_data` after edge N.
- R3: When `in_valid` is 0 at an edge, `out_data` keeps its previous value whatever the other inputs carry.
- R4: Kind code 0 (word): the result is `in_data` rotated right by 8 × `in_addr_lo[1:0]` bits.
- R5: Kind code 1 (unsigned halfword) with `in_addr_lo[0]`=0: the result is `in_data[15:0]` zero-extended. `in_data[31:16]` has no effect.
- R6: Kind code 1 with `in_addr_lo[0]`=1: the result is {h[7:0], 16'h0000, h[15:8]}, where h = `in_data[15:0]`.
- R7: Kind code 2 (signed halfword) with `in_addr_lo[0]`=0: the result is h sign-extended from bit 15.
- R8: Kind code 2 with `in_addr_lo[0]`=1: the result is h[15:8] sign-extended from its bit 7.
- R9: Kind code 3 (unsigned byte): the result is byte lane `in_addr_lo[1:0]` of `in_data` (lane k = bits 8k+7..8k), zero-extended.
- R10: Kind code 4 (signed byte): the same lane as R9, sign-extended from its bit 7.
- R11: Kind codes 5, 6 and 7 are treated exactly as kind code 0.
- R12: For kind codes 1 and 2, `in_addr_lo[1]` has no effect on the result.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A load request is presented this cycle |
| in_kind | input | 3 | Load kind: 0 word, 1 unsigned half, 2 signed half, 3 unsigned byte, 4 signed byte |
| in_addr_lo | input | 2 | Low bits of the request address |
| in_data | input | 32 | Aligned word fetched by the read decoder (halfword in bits 15:0) |
| out_valid | output | 1 | Writeback value is valid |
| out_data | output | 32 | Writeback value |

## Verification
The only state is the output register and its valid bit. A fault there shows up on the ports within one cycle, either as a valid pulse that is missing or extra, or as a result that changes during an idle cycle. A wrong choice of rotation amount, byte lane or extension is also visible on the very next cycle, in the upper bits or in the byte order of `out_data`. The stimulus therefore sweeps every kind code against every address offset. The data patterns are chosen so that the bytes differ from each other and their top bits differ in sign.

// File: rtl/ldalign_pkg.sv
package ldalign_pkg;

  localparam int unsigned KIND_W = 3;

  typedef enum logic [KIND_W-1:0] {
    LDK_WORD  = 3'd0,
    LDK_UHALF = 3'd1,
    LDK_SHALF = 3'd2,
    LDK_UBYTE = 3'd3,
    LDK_SBYTE = 3'd4
  } ld_kind_e;

  typedef enum logic [1:0] {
    PATH_WORD = 2'd0,
    PATH_HALF = 2'd1,
    PATH_BYTE = 2'd2
  } ld_path_e;

  typedef struct packed {
    ld_path_e path;
    logic     sext;
    logic     reserved;
  } ld_sel_t;

  // Reserved codes fall back to a word load.
  function automatic ld_sel_t decode_kind(input logic [KIND_W-1:0] k);
    ld_sel_t s;
    s.path     = PATH_WORD;
    s.sext     = 1'b0;
    s.reserved = 1'b0;
    case (k)
      LDK_WORD:  s.path = PATH_WORD;
      LDK_UHALF: s.path = PATH_HALF;
      LDK_SHALF: begin s.path = PATH_HALF; s.sext = 1'b1; end
      LDK_UBYTE: s.path = PATH_BYTE;
      LDK_SBYTE: begin s.path = PATH_BYTE; s.sext = 1'b1; end
      default:   s.reserved = 1'b1;
    endcase
    return s;
  endfunction

endpackage

// File: rtl/ld_word_rotator.sv
// Byte-granular right rotation of the fetched word. Lane count must be a power of two.
module ld_word_rotator #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  ofs_i,
  output logic [DATA_W-1:0] rot_o
);

  function automatic logic [OFS_W-1:0] src_lane(input int unsigned dst,
                                                 input logic [OFS_W-1:0] ofs);
    return OFS_W'(dst) + ofs;
  endfunction

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    logic [OFS_W-1:0] src;
    always_comb begin
      src = src_lane(g, ofs_i);
      rot_o[8*g +: 8] = data_i[{src, 3'b000} +: 8];
    end
  end

endmodule

// File: rtl/ld_half_former.sv
// Forms the halfword result: rotation by one byte at odd addresses, optional sign extension.
module ld_half_former #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned HALF_W = 16,
  localparam int unsigned PAD_W  = DATA_W - HALF_W
) (
  input  logic [HALF_W-1:0] half_i,
  input  logic              odd_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] res_o
);

  function automatic logic [DATA_W-1:0] rot_half(input logic [HALF_W-1:0] h);
    return {h[7:0], {PAD_W{1'b0}}, h[15:8]};
  endfunction

  function automatic logic [DATA_W-1:0] ext_half(input logic [HALF_W-1:0] h,
                                                 input logic s);
    return {{PAD_W{s & h[HALF_W-1]}}, h};
  endfunction

  function automatic logic [DATA_W-1:0] ext_hi_byte(input logic [HALF_W-1:0] h);
    return {{(DATA_W-8){h[HALF_W-1]}}, h[15:8]};
  endfunction

  always_comb begin
    if (!odd_i)       res_o = ext_half(half_i, sext_i);
    else if (sext_i)  res_o = ext_hi_byte(half_i);
    else              res_o = rot_half(half_i);
  end

endmodule

// File: rtl/ld_byte_picker.sv
// Selects one byte lane and extends it.
module ld_byte_picker #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic [DATA_W-1:0] data_i,
  input  logic [OFS_W-1:0]  lane_i,
  input  logic              sext_i,
  output logic [DATA_W-1:0] res_o
);

  function automatic logic [DATA_W-1:0] ext_byte(input logic [7:0] b, input logic s);
    return {{(DATA_W-8){s & b[7]}}, b};
  endfunction

  logic [7:0] lane_byte;

  always_comb begin
    lane_byte = data_i[{lane_i, 3'b000} +: 8];
    res_o     = ext_byte(lane_byte, sext_i);
  end

endmodule

// File: rtl/ld_align_unit.sv
module ld_align_unit
  import ldalign_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                in_valid,
  input  logic [KIND_W-1:0]   in_kind,
  input  logic [OFS_W-1:0]    in_addr_lo,
  input  logic [DATA_W-1:0]   in_data,
  output logic                out_valid,
  output logic [DATA_W-1:0]   out_data
);

  // Named internal events, visible to the bound checker
  ld_sel_t           sel;
  logic              kind_reserved;
  logic              misaligned;
  logic              take_result;
  logic [DATA_W-1:0] word_res;
  logic [DATA_W-1:0] half_res;
  logic [DATA_W-1:0] byte_res;
  logic [DATA_W-1:0] next_res;

  always_comb begin
    sel           = decode_kind(in_kind);
    kind_reserved = sel.reserved;
    take_result   = in_valid;
    case (sel.path)
      PATH_HALF: misaligned = in_addr_lo[0];
      PATH_BYTE: misaligned = 1'b0;
      default:   misaligned = |in_addr_lo;
    endcase
  end

  ld_word_rotator #(.DATA_W(DATA_W)) u_rot (
    .data_i (in_data),
    .ofs_i  (in_addr_lo),
    .rot_o  (word_res)
  );

  ld_half_former #(.DATA_W(DATA_W)) u_half (
    .half_i (in_data[15:0]),
    .odd_i  (in_addr_lo[0]),
    .sext_i (sel.sext),
    .res_o  (half_res)
  );

  ld_byte_picker #(.DATA_W(DATA_W)) u_byte (
    .data_i (in_data),
    .lane_i (in_addr_lo),
    .sext_i (sel.sext),
    .res_o  (byte_res)
  );

  always_comb begin
    case (sel.path)
      PATH_HALF: next_res = half_res;
      PATH_BYTE: next_res = byte_res;
      default:   next_res = word_res;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= take_result;
      if (take_result) out_data <= next_res;
    end
  end

endmodule

// File: rtl/ld_align_chk.sv
module ld_align_chk #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned LANES = DATA_W / 8,
  localparam int unsigned OFS_W = (LANES > 1) ? $clog2(LANES) : 1
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic [2:0]        in_kind,
  input logic [OFS_W-1:0]  in_addr_lo,
  input logic [DATA_W-1:0] in_data,
  input logic              out_valid,
  input logic [DATA_W-1:0] out_data,
  input logic              kind_reserved,
  input logic              misaligned
);

  AST_VALID_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid); // R2
  AST_IDLE_NO_VALID: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid); // R2
  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> $stable(out_data)); // R3
  AST_ALIGNED_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd0 && !misaligned) |=> out_data == $past(in_data)); // R4
  AST_UHALF_EVEN_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd1 && !in_addr_lo[0]) |=> out_data[DATA_W-1:16] == '0); // R5
  AST_SHALF_ODD_BYTE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd2 && in_addr_lo[0])
      |=> out_data == {{(DATA_W-8){$past(in_data[15])}}, $past(in_data[15:8])}); // R8
  AST_UBYTE_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd3) |=> out_data[DATA_W-1:8] == '0); // R9
  AST_SBYTE_EXTENDED: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_kind == 3'd4) |=> out_data[DATA_W-1:7] == {(DATA_W-7){out_data[7]}}); // R10
  AST_RESERVED_AS_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && kind_reserved && !misaligned) |=> out_data == $past(in_data)); // R11

endmodule

bind ld_align_unit ld_align_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst_n         (rst_n),
  .in_valid      (in_valid),
  .in_kind       (in_kind),
  .in_addr_lo    (in_addr_lo),
  .in_data       (in_data),
  .out_valid     (out_valid),
  .out_data      (out_data),
  .kind_reserved (kind_reserved),
  .misaligned    (misaligned)
);

// File: tb/sim_ld_align_unit.sv
`timescale 1ns/1ps
module sim_ld_align_unit;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic [2:0]  in_kind = '0;
  logic [1:0]  in_addr_lo = '0;
  logic [31:0] in_data = '0;
  logic        out_valid;
  logic [31:0] out_data;

  int total = 0;
  int bad = 0;
  bit finished = 1'b0;
  logic [31:0] last_out = '0;

  always #2.5 clk = ~clk;

  ld_align_unit u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_kind(in_kind),
    .in_addr_lo(in_addr_lo), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data)
  );

  function automatic logic [31:0] sx8(input logic [7:0] b);
    return {{24{b[7]}}, b};
  endfunction

  function automatic logic [31:0] ref_load(input logic [2:0] k, input logic [1:0] a,
                                           input logic [31:0] d);
    logic [63:0] dd;
    logic [31:0] h32;
    logic [63:0] hh;
    logic [7:0]  b;
    dd  = {d, d} >> (8 * a);
    h32 = {16'h0000, d[15:0]};
    hh  = {h32, h32} >> (8 * a[0]);
    b   = 8'(d >> (8 * a));
    case (k)
      3'd1: return hh[31:0];
      3'd2: return a[0] ? sx8(d[15:8]) : {{16{d[15]}}, d[15:0]};
      3'd3: return {24'h0, b};
      3'd4: return sx8(b);
      default: return dd[31:0];
    endcase
  endfunction

  function automatic string req_tag(input logic [2:0] k, input logic [1:0] a);
    case (k)
      3'd0: return "R4";
      3'd1: return a[0] ? "R6/R12" : "R5/R12";
      3'd2: return a[0] ? "R8/R12" : "R7/R12";
      3'd3: return "R9";
      3'd4: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%08h expected=%08h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [2:0] k, input logic [1:0] a,
                      input logic [31:0] d);
    logic [31:0] exp;
    string tag;
    @(negedge clk);
    in_valid = v; in_kind = k; in_addr_lo = a; in_data = d;
    if (v) begin exp = ref_load(k, a, d); tag = req_tag(k, a); end
    else begin exp = last_out; tag = "R3"; end
    @(posedge clk); #1;
    check("R2 valid", {31'h0, out_valid}, {31'h0, v});
    check(tag, out_data, exp);
    last_out = exp;
  endtask

  initial begin
    #1000000;
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1;
    check("R1 valid in reset", {31'h0, out_valid}, 32'h0);
    check("R1 data in reset", out_data, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    check("R1 valid after release", {31'h0, out_valid}, 32'h0);
    check("R1 data after release", out_data, 32'h0);

    // Directed corners
    for (int a = 0; a < 4; a++) step(1'b1, 3'd0, 2'(a), 32'h11223344);   // R4
    step(1'b1, 3'd1, 2'd0, 32'hFFFF1234);                               // R5 upper ignored
    step(1'b1, 3'd1, 2'd1, 32'h0000ABCD);                               // R6
    step(1'b1, 3'd1, 2'd3, 32'h5555ABCD);                               // R6/R12
    step(1'b1, 3'd2, 2'd0, 32'h00008001);                               // R7
    step(1'b1, 3'd2, 2'd2, 32'h00007FFE);                               // R7/R12
    step(1'b1, 3'd2, 2'd1, 32'h000080FF);                               // R8
    step(1'b1, 3'd2, 2'd3, 32'h00007F80);                               // R8/R12
    for (int a = 0; a < 4; a++) step(1'b1, 3'd3, 2'(a), 32'h80FF7F01);   // R9
    for (int a = 0; a < 4; a++) step(1'b1, 3'd4, 2'(a), 32'h80FF7F01);   // R10
    for (int k = 5; k < 8; k++) step(1'b1, 3'(k), 2'(k - 4), 32'hA1B2C3D4); // R11
    step(1'b0, 3'd4, 2'd3, 32'hDEADBEEF);                               // R3 idle
    step(1'b0, 3'd0, 2'd1, 32'h01234567);                               // R3 idle

    // Constrained random: fixed seed, every kind against every offset
    void'($urandom(32'd1234));
    for (int i = 0; i < 3000; i++) begin
      logic v;
      v = ($urandom % 5) != 0;
      step(v, 3'($urandom % 8), 2'($urandom % 4), $urandom);
    end

    finished = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule